// File: doc/BRIEF.md
# Byte-Staged 16-bit Register Access Port

This block sits between a byte-wide internal bus and a small register file holding four 16-bit words and four 8-bit control bytes. Software writes a 16-bit word as two byte transfers: the upper byte first, then the lower byte. The upper byte only lands in a holding byte that all four words share. The lower-byte transfer then loads the addressed word with the held upper byte and the new lower byte on one clock edge, so logic reading a word never sees one half old and one half new.

The holding byte keeps its value after a commit. A run of lower-byte writes, to the same word or to different words, reuses the last upper byte until a new one is written. Reads are combinational: the bus read data shows the addressed byte of the live register, never the holding byte. Addresses outside the map read as zero, and writes to them change nothing.

Byte address map (ADDR_W = 4): word k upper half at 2k, lower half at 2k+1 (k = 0..3), control byte j at 8+j (j = 0..3), and 12..15 unused.

Top module: `rw16_regfile`

## Requirements
- R1: After reset, every word, every control byte and the holding byte are 0x00, so every address reads 0x00.
- R2: A write to an upper-half address (even address below 8) loads only the holding byte; no word or control byte changes.
- R3: A write to a lower-half address (odd address below 8) loads word k with {holding byte, write data} on that clock edge, and the new value is visible at word_q and over the bus from the next cycle.
- R4: The holding byte keeps its value across later lower-half writes until a new upper-half write replaces it.
- R5: The holding byte is shared, so an upper byte written through one word's address is committed by a lower-half write to any other word.
- R6: A write to address 8+j loads control byte j directly with the write data, visible at ctrl_q from the next cycle.
- R7: Bus read data is the addressed byte of the current register contents in the same cycle, with the upper half at the even address and the lower half at the odd address.
- R8: Writes to addresses 12..15 change no register and no holding byte; reads from them return 0x00.
- R9: While bus_we is low no register and no holding byte changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr, combinational |
| word_q | output | NUM_WORDS*16 (64) | Word k at bits 16k+15..16k |
| ctrl_q | output | NUM_CTRL*8 (32) | Control byte j at bits 8j+7..8j |

## Verification
A write takes effect on the edge where bus_we is high, so word_q, ctrl_q and any read of the written byte are due one cycle later; bus_rdata for a given address is due in the same cycle the address is presented, with no register in the path. The driver presents each access just after a falling edge and pushes the expected value into the scoreboard queue for that cycle; the monitor pops and compares one nanosecond after the following rising edge, when the write of the previous cycle has settled and bus_we is low so nothing moves. Staging is checked through the ports only: a held upper byte is proven by the word a later lower-half write produces.

// File: rtl/rw16_pkg.sv
package rw16_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int IDX_W  = 8;

  typedef struct packed {
    logic             hit_hi;
    logic             hit_lo;
    logic             hit_ctl;
    logic [IDX_W-1:0] idx;
  } dec_t;

  // Byte address to register selection.
  function automatic dec_t decode_addr(input int unsigned a,
                                       input int unsigned nw,
                                       input int unsigned nc);
    dec_t d;
    d = '0;
    if (a < 2 * nw) begin
      d.idx    = IDX_W'(a / 2);
      d.hit_hi = ((a % 2) == 0);
      d.hit_lo = ((a % 2) == 1);
    end else if (a < 2 * nw + nc) begin
      d.hit_ctl = 1'b1;
      d.idx     = IDX_W'(a - 2 * nw);
    end
    return d;
  endfunction

  // Word assembled from the held upper byte and the new lower byte.
  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/rw16_decode.sv
module rw16_decode
  import rw16_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_CTRL  = 4,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output dec_t              dec,
  output logic              hi_wr,
  output logic              lo_wr,
  output logic              ctl_wr
);

  always_comb begin
    dec    = decode_addr(32'(addr), NUM_WORDS, NUM_CTRL);
    hi_wr  = we && dec.hit_hi;
    lo_wr  = we && dec.hit_lo;
    ctl_wr = we && dec.hit_ctl;
  end

endmodule

// File: rtl/rw16_stage.sv
module rw16_stage
  import rw16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/rw16_wordbank.sv
module rw16_wordbank
  import rw16_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [IDX_W-1:0]            idx,
  input  logic [BYTE_W-1:0]           hi_byte,
  input  logic [BYTE_W-1:0]           lo_byte,
  output logic [NUM_WORDS*WORD_W-1:0] q_flat
);

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    logic sel;
    assign sel = commit && (idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q_flat[gi*WORD_W +: WORD_W] <= '0;
      else if (sel) q_flat[gi*WORD_W +: WORD_W] <= join_bytes(hi_byte, lo_byte);
    end
  end

endmodule

// File: rtl/rw16_ctrlbank.sv
module rw16_ctrlbank
  import rw16_pkg::*;
#(
  parameter int NUM_CTRL = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [IDX_W-1:0]           idx,
  input  logic [BYTE_W-1:0]          din,
  output logic [NUM_CTRL*BYTE_W-1:0] q_flat
);

  for (genvar gj = 0; gj < NUM_CTRL; gj++) begin : g_ctl
    logic sel;
    assign sel = load && (idx == IDX_W'(gj));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q_flat[gj*BYTE_W +: BYTE_W] <= '0;
      else if (sel) q_flat[gj*BYTE_W +: BYTE_W] <= din;
    end
  end

endmodule

// File: rtl/rw16_rdmux.sv
module rw16_rdmux
  import rw16_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_CTRL  = 4
) (
  input  dec_t                        dec,
  input  logic [NUM_WORDS*WORD_W-1:0] word_flat,
  input  logic [NUM_CTRL*BYTE_W-1:0]  ctrl_flat,
  output logic [BYTE_W-1:0]           rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (dec.idx == IDX_W'(i)) begin
        if (dec.hit_hi) rdata = word_flat[i*WORD_W + BYTE_W +: BYTE_W];
        if (dec.hit_lo) rdata = word_flat[i*WORD_W +: BYTE_W];
      end
    end
    for (int j = 0; j < NUM_CTRL; j++) begin
      if (dec.hit_ctl && dec.idx == IDX_W'(j))
        rdata = ctrl_flat[j*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/rw16_regfile.sv
module rw16_regfile
  import rw16_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_CTRL  = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [BYTE_W-1:0]           bus_wdata,
  output logic [BYTE_W-1:0]           bus_rdata,
  output logic [NUM_WORDS*WORD_W-1:0] word_q,
  output logic [NUM_CTRL*BYTE_W-1:0]  ctrl_q
);

  // Named events brought out for the bound checker.
  dec_t              dec;
  logic              hi_wr;
  logic              lo_wr;
  logic              ctl_wr;
  logic [BYTE_W-1:0] stage_q;
  logic [IDX_W-1:0]  wr_idx;

  assign wr_idx = dec.idx;

  rw16_decode #(
    .NUM_WORDS(NUM_WORDS), .NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr(bus_addr), .we(bus_we), .dec(dec),
    .hi_wr(hi_wr), .lo_wr(lo_wr), .ctl_wr(ctl_wr)
  );

  rw16_stage u_stage (
    .clk(clk), .rst_n(rst_n), .load(hi_wr), .din(bus_wdata), .q(stage_q)
  );

  rw16_wordbank #(.NUM_WORDS(NUM_WORDS)) u_words (
    .clk(clk), .rst_n(rst_n), .commit(lo_wr), .idx(wr_idx),
    .hi_byte(stage_q), .lo_byte(bus_wdata), .q_flat(word_q)
  );

  rw16_ctrlbank #(.NUM_CTRL(NUM_CTRL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(ctl_wr), .idx(wr_idx),
    .din(bus_wdata), .q_flat(ctrl_q)
  );

  rw16_rdmux #(.NUM_WORDS(NUM_WORDS), .NUM_CTRL(NUM_CTRL)) u_rdmux (
    .dec(dec), .word_flat(word_q), .ctrl_flat(ctrl_q), .rdata(bus_rdata)
  );

endmodule

// File: rtl/rw16_checker.sv
module rw16_checker
  import rw16_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_CTRL  = 4,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [BYTE_W-1:0]           bus_wdata,
  input logic [BYTE_W-1:0]           bus_rdata,
  input logic [NUM_WORDS*WORD_W-1:0] word_q,
  input logic [NUM_CTRL*BYTE_W-1:0]  ctrl_q,
  input logic [BYTE_W-1:0]           stage_q,
  input logic                        hi_wr,
  input logic                        lo_wr,
  input logic                        ctl_wr,
  input logic [IDX_W-1:0]            wr_idx
);

  localparam int unsigned MAP_END = 2 * NUM_WORDS + NUM_CTRL;

  // R2: an upper-half write leaves every word and control byte untouched
  p_hi_only_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> ($stable(word_q) && $stable(ctrl_q)));

  // R3: lower-half write commits held byte and new byte together
  p_commit_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (word_q[$past(wr_idx)*WORD_W +: WORD_W] == {$past(stage_q), $past(bus_wdata)}));

  // R4: holding byte only moves on an upper-half write
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(stage_q));

  // R6: control byte loaded directly
  p_ctrl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctrl_q[$past(wr_idx)*BYTE_W +: BYTE_W] == $past(bus_wdata)));

  // R8: addresses beyond the map read zero and absorb writes
  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bus_addr) >= MAP_END) |-> (bus_rdata == '0));

  p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && 32'(bus_addr) >= MAP_END) |=>
      ($stable(word_q) && $stable(ctrl_q) && $stable(stage_q)));

  // R9: nothing changes without a write strobe
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(word_q) && $stable(ctrl_q) && $stable(stage_q)));

  // At most one write event per cycle
  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_wr, lo_wr, ctl_wr}));

endmodule

bind rw16_regfile rw16_checker #(
  .NUM_WORDS(NUM_WORDS), .NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .word_q(word_q),
  .ctrl_q(ctrl_q), .stage_q(stage_q), .hi_wr(hi_wr), .lo_wr(lo_wr),
  .ctl_wr(ctl_wr), .wr_idx(wr_idx)
);

// File: tb/rw16_regfile_tb.sv
`timescale 1ns/1ps
module rw16_regfile_tb;

  localparam int NW = 4;
  localparam int NC = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NW*16-1:0] word_q;
  logic [NC*8-1:0]  ctrl_q;

  always #4 clk = ~clk;

  rw16_regfile #(.NUM_WORDS(NW), .NUM_CTRL(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .word_q(word_q), .ctrl_q(ctrl_q)
  );

  // Reference model
  logic [15:0] m_word [NW];
  logic [7:0]  m_ctrl [NC];
  logic [7:0]  m_hold;

  typedef struct {
    int    kind;   // 0 bus read, 1 word port, 2 control port
    int    idx;
    int    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic int model_read(input int a);
    if (a < 2 * NW) return (a % 2 == 0) ? int'(m_word[a/2][15:8]) : int'(m_word[a/2][7:0]);
    if (a < 2 * NW + NC) return int'(m_ctrl[a - 2*NW]);
    return 0;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    if (bus_we) begin
      if (a < 2 * NW) begin
        if (a % 2 == 0) m_hold = 8'(d);
        else m_word[a/2] = {m_hold, 8'(d)};
      end else if (a < 2 * NW + NC) m_ctrl[a - 2*NW] = 8'(d);
    end
  endtask

  task automatic idle_we0(input int a, input int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = 8'(d); bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = AW'(a); bus_we = 1'b0; bus_wdata = 8'h5F;
    it.kind = 0; it.idx = a; it.exp = model_read(a); it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_port(input int kind, input int i, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0;
    it.kind = kind; it.idx = i; it.tag = tag;
    it.exp = (kind == 1) ? int'(m_word[i]) : int'(m_ctrl[i]);
    sb_q.push_back(it);
  endtask

  // Monitor: compare one item per cycle, 1 ns after the rising edge
  initial begin
    forever begin
      item_t it;
      int act;
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        case (it.kind)
          0: act = int'(bus_rdata);
          1: act = int'(word_q[it.idx*16 +: 16]);
          default: act = int'(ctrl_q[it.idx*8 +: 8]);
        endcase
        n_chk++;
        if (act != it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d idx=%0d actual=0x%0h expected=0x%0h",
                   it.tag, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) m_word[i] = '0;
    for (int j = 0; j < NC; j++) m_ctrl[j] = '0;
    m_hold = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state over every address and both output buses
    for (int a = 0; a < 16; a++) rd(a, "R1_reset_read");
    for (int i = 0; i < NW; i++) chk_port(1, i, "R1_reset_word");
    for (int j = 0; j < NC; j++) chk_port(2, j, "R1_reset_ctrl");

    // R2: upper-half write is staged only
    wr(0, 8'hAB);
    chk_port(1, 0, "R2_word_unchanged");
    rd(0, "R2_read_hi_still_zero");
    rd(1, "R2_read_lo_still_zero");

    // R3: lower-half write commits the whole word
    wr(1, 8'hCD);
    chk_port(1, 0, "R3_commit_word0");
    rd(0, "R3_read_hi");
    rd(1, "R3_read_lo");

    // R4: held byte reused on repeated lower writes
    wr(1, 8'h11);
    chk_port(1, 0, "R4_reuse_same_word");
    wr(1, 8'h12);
    rd(0, "R4_hi_persists");

    // R5: shared holding byte across words
    wr(3, 8'h22);
    chk_port(1, 1, "R5_shared_word1");
    wr(4, 8'h5A);
    wr(7, 8'h3C);
    chk_port(1, 3, "R5_cross_word3");
    chk_port(1, 2, "R5_word2_untouched");

    // R6: control bytes
    wr(8, 8'h81); wr(9, 8'h42); wr(10, 8'hFF); wr(11, 8'h00);
    for (int j = 0; j < NC; j++) chk_port(2, j, "R6_ctrl_port");
    rd(9, "R6_ctrl_read");
    chk_port(1, 3, "R6_words_untouched");

    // R7: same-cycle read of each byte, held byte not visible
    wr(6, 8'hEE);
    rd(6, "R7_hi_reads_register_not_hold");
    rd(7, "R7_lo");
    rd(2, "R7_word1_hi");

    // R8: unmapped addresses
    wr(12, 8'hFF); wr(15, 8'h99);
    rd(12, "R8_unmapped_read12");
    rd(15, "R8_unmapped_read15");
    for (int i = 0; i < NW; i++) chk_port(1, i, "R8_words_unchanged");
    for (int j = 0; j < NC; j++) chk_port(2, j, "R8_ctrl_unchanged");
    wr(5, 8'h77);
    chk_port(1, 2, "R8_hold_unchanged");

    // R9: strobe low does nothing
    idle_we0(0, 8'h01);
    idle_we0(3, 8'h02);
    idle_we0(10, 8'h03);
    chk_port(1, 1, "R9_word1_unchanged");
    chk_port(2, 2, "R9_ctrl2_unchanged");
    wr(1, 8'h44);
    chk_port(1, 0, "R9_hold_unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule